// File: doc/BRIEF.md
# 1-Wire Bus Timing Master

This block produces every waveform a host needs on one open-drain 1-Wire line: the bus reset with presence detection, single-bit time slots and whole-byte transfers. All timing derives from a 6 µs tick, obtained by dividing the system clock by its frequency in MHz times six. The pad is either pulled low (`lineOe` high, output value 0) or released (`lineOe` low). The block never drives the line high.

A host issues one command at a time over a valid/ready handshake and gets one response pulse when the command is finished. Every slot lasts 72 µs and serves both directions. A slot that sends a 1 also samples the line, so writing a byte always returns the byte seen on the wire, and reading a byte means sending 0xFF. Single-bit commands let a controller build search or polling sequences one slot at a time. A 2-flop synchronizer sits on the line input before any sampling.

Top module: `onewire_master`

## Requirements
- R1: After reset `busy`, `lineOe`, `rspValid`, `rspData` and `rspPresence` are 0, and `cmdReady` is 1.
- R2: A command is taken on a clock edge where `cmdValid` and `cmdReady` are both high. `cmdReady` equals the inverse of `busy`. `busy` is high from the cycle after the command is taken. A `cmdValid` raised while busy has no effect on the line, on `busy` or on the responses.
- R3: One tick is `CLK_MHZ*6` clock cycles. A command lasts exactly its tick count times that many cycles, counted from the first busy cycle.
- R4: A reset command (`cmdKind` = 2'b00) lasts 170 ticks. The line is released in ticks 0 to 9, held low in ticks 10 to 89, and released in ticks 90 to 169.
- R5: During a reset the line is sampled 32 times, at the ends of ticks 93, 95, …, 155. `rspPresence` becomes 1 when at least one sample is low, and 0 otherwise.
- R6: A slot lasts 12 ticks. The line is released in ticks 0 and 1 and low in tick 2. For a 1 bit the line is released in ticks 3 to 11. For a 0 bit it stays low through tick 11.
- R7: For a 1 bit the received value is the synchronized line sampled at the end of slot tick 3. For a 0 bit the received value is 0.
- R8: A byte command (`cmdKind` = 2'b10) runs 8 slots that send `cmdData` least significant bit first. `rspData` bit i is the value received in slot i.
- R9: A bit command (`cmdKind` = 2'b01) runs one slot that sends `cmdData[0]`. `rspData` is then the received value in bit 0, with zeros above it.
- R10: `rspValid` pulses for one cycle, in the first cycle in which `busy` is low again. A reset updates only `rspPresence`, and a bit or byte command updates only `rspData`. Both hold their values between responses.
- R11: The reserved code `cmdKind` = 2'b11 is never taken. `busy` stays low, the line stays released and no response follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | High while idle; a command is taken when valid and ready are both high |
| cmdKind | input | 2 | 00 reset, 01 bit, 10 byte, 11 reserved |
| cmdData | input | DATA_W | Bits to send; bit mode uses bit 0 |
| busy | output | 1 | A sequence is running |
| rspValid | output | 1 | One-cycle completion pulse |
| rspData | output | DATA_W | Received bits of the last bit or byte command |
| rspPresence | output | 1 | Presence result of the last reset |
| lineIn | input | 1 | Raw line level from the pad |
| lineOe | output | 1 | 1 pulls the line low, 0 releases it |

## Verification
`busy` and `lineOe` follow a fixed tick table from the first busy cycle, so the bench keeps a cycle counter for each command. It predicts both signals, together with `cmdReady`, and compares them with the design on the falling edge of every clock. The response is due `ticks × CLK_MHZ*6` cycles after the command is taken: 170 ticks for a reset, 12 for a bit and 96 for a byte. The model predicts the `rspValid` pulse in exactly that cycle and checks the data when the pulse appears. A behavioural device pulls the line for windows that start on observed `lineOe` edges. Its presence windows are placed to fall clearly inside the sample span, between two samples, before the first sample or after the last one, so the 2-cycle synchronizer delay cannot change any expected result.

// File: rtl/ow_pkg.sv
package ow_pkg;
  localparam int TICK_US = 6;

  // reset sequence, in ticks
  localparam int RST_REL_T    = 60 / TICK_US;
  localparam int RST_LOW_T    = 480 / TICK_US;
  localparam int PRES_WAIT_T  = 24 / TICK_US;
  localparam int PRES_STEP_T  = 12 / TICK_US;
  localparam int PRES_SAMPLES = 32;
  localparam int PRES_TAIL_T  = 72 / TICK_US;
  localparam int PRES_FIRST_T = RST_REL_T + RST_LOW_T + PRES_WAIT_T - 1;
  localparam int RST_TOTAL_T  = RST_REL_T + RST_LOW_T + PRES_WAIT_T
                              + PRES_SAMPLES * PRES_STEP_T + PRES_TAIL_T;

  // slot, in ticks
  localparam int SLOT_LOW_T    = 12 / TICK_US;
  localparam int SLOT_SAMPLE_T = SLOT_LOW_T + 1;
  localparam int SLOT_TOTAL_T  = 72 / TICK_US;

  localparam int POS_W = $clog2(RST_TOTAL_T);

  typedef enum logic [1:0] {
    KIND_RESET = 2'b00,
    KIND_BIT   = 2'b01,
    KIND_BYTE  = 2'b10,
    KIND_RSVD  = 2'b11
  } owKind_e;

  typedef struct packed {
    logic load;
    logic lineLow;
    logic slotSample;
    logic presSample;
    logic bitShift;
    logic done;
    logic doneIsReset;
    logic doneIsByte;
  } owStrobe_t;
endpackage

// File: rtl/ow_tick_gen.sv
module ow_tick_gen #(
  parameter int DIV = 600
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  output logic tickStb
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cnt <= '0;
    else if (!run)             cnt <= '0;
    else if (cnt == CNT_LAST)  cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  assign tickStb = run && (cnt == CNT_LAST);
endmodule

// File: rtl/ow_seq_ctrl.sv
module ow_seq_ctrl
  import ow_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdKind,
  input  logic       txBit,
  input  logic       tickStb,
  output logic       busy,
  output owStrobe_t  strb
);
  localparam int SLOT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [POS_W-1:0]  RST_LAST_P   = POS_W'(RST_TOTAL_T - 1);
  localparam logic [POS_W-1:0]  SLOT_LAST_P  = POS_W'(SLOT_TOTAL_T - 1);
  localparam logic [POS_W-1:0]  LOW_BEG_P    = POS_W'(RST_REL_T);
  localparam logic [POS_W-1:0]  LOW_END_P    = POS_W'(RST_REL_T + RST_LOW_T);
  localparam logic [POS_W-1:0]  PRES_FIRST_P = POS_W'(PRES_FIRST_T);
  localparam logic [POS_W-1:0]  PRES_SPAN_P  = POS_W'(PRES_SAMPLES * PRES_STEP_T);
  localparam logic [POS_W-1:0]  PRES_MASK_P  = POS_W'(PRES_STEP_T - 1);
  localparam logic [POS_W-1:0]  SLOT_LOW_P   = POS_W'(SLOT_LOW_T);
  localparam logic [POS_W-1:0]  SLOT_SAMP_P  = POS_W'(SLOT_SAMPLE_T);
  localparam logic [SLOT_W-1:0] SLOT_FINAL   = SLOT_W'(DATA_W - 1);

  logic              busyQ;
  owKind_e           kindQ;
  logic [POS_W-1:0]  pos;
  logic [SLOT_W-1:0] slotIdx;

  logic             accept, isReset, lastPos, lastSlot, endSeq;
  logic             lowReset, lowSlot, presHit;
  logic [POS_W-1:0] presOff;

  always_comb begin
    accept   = cmdValid && !busyQ && (owKind_e'(cmdKind) != KIND_RSVD);
    isReset  = (kindQ == KIND_RESET);
    lastPos  = isReset ? (pos == RST_LAST_P) : (pos == SLOT_LAST_P);
    lastSlot = (kindQ != KIND_BYTE) || (slotIdx == SLOT_FINAL);
    endSeq   = busyQ && tickStb && lastPos && lastSlot;
    presOff  = pos - PRES_FIRST_P;
    presHit  = (pos >= PRES_FIRST_P) && (presOff < PRES_SPAN_P)
               && ((presOff & PRES_MASK_P) == '0);
    lowReset = (pos >= LOW_BEG_P) && (pos < LOW_END_P);
    lowSlot  = (pos == SLOT_LOW_P) || ((pos > SLOT_LOW_P) && !txBit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      kindQ   <= KIND_RESET;
      pos     <= '0;
      slotIdx <= '0;
    end else if (accept) begin
      busyQ   <= 1'b1;
      kindQ   <= owKind_e'(cmdKind);
      pos     <= '0;
      slotIdx <= '0;
    end else if (busyQ && tickStb) begin
      if (lastPos) begin
        pos <= '0;
        if (lastSlot) busyQ   <= 1'b0;
        else          slotIdx <= slotIdx + 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  always_comb begin
    strb.load        = accept;
    strb.lineLow     = busyQ && (isReset ? lowReset : lowSlot);
    strb.slotSample  = busyQ && !isReset && tickStb && (pos == SLOT_SAMP_P);
    strb.presSample  = busyQ && isReset && tickStb && presHit;
    strb.bitShift    = busyQ && !isReset && tickStb && lastPos;
    strb.done        = endSeq;
    strb.doneIsReset = isReset;
    strb.doneIsByte  = (kindQ == KIND_BYTE);
  end

  assign busy = busyQ;
endmodule

// File: rtl/ow_datapath.sv
module ow_datapath
  import ow_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  owStrobe_t         strb,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              lineIn,
  output logic              txBit,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspPresence
);
  logic [1:0]        syncQ;
  logic              lineSync;
  logic [DATA_W-1:0] shiftQ;
  logic              sampQ;
  logic              presAcc;
  logic              rxBit;
  logic [DATA_W-1:0] shiftNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], lineIn};
  end
  assign lineSync = syncQ[1];

  assign txBit     = shiftQ[0];
  assign rxBit     = txBit & sampQ;
  assign shiftNext = {rxBit, shiftQ[DATA_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              shiftQ <= '0;
    else if (strb.load)     shiftQ <= cmdData;
    else if (strb.bitShift) shiftQ <= shiftNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sampQ <= 1'b1;
    else if (strb.slotSample) sampQ <= lineSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                presAcc <= 1'b0;
    else if (strb.load)                       presAcc <= 1'b0;
    else if (strb.presSample && !lineSync)    presAcc <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspData     <= '0;
      rspPresence <= 1'b0;
    end else begin
      rspValid <= strb.done;
      if (strb.done && strb.doneIsReset)
        rspPresence <= presAcc;
      if (strb.done && !strb.doneIsReset)
        rspData <= strb.doneIsByte ? shiftNext : {{(DATA_W-1){1'b0}}, rxBit};
    end
  end
endmodule

// File: rtl/onewire_master.sv
module onewire_master
  import ow_pkg::*;
#(
  parameter int CLK_MHZ = 100,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdKind,
  input  logic [DATA_W-1:0] cmdData,
  output logic              busy,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspPresence,
  input  logic              lineIn,
  output logic              lineOe
);
  localparam int TICK_DIV = CLK_MHZ * TICK_US;

  owStrobe_t strb;
  logic      tickStb;
  logic      txBit;
  logic      busyInt;

  ow_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rstN(rstN), .run(busyInt), .tickStb(tickStb)
  );

  ow_seq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .txBit(txBit), .tickStb(tickStb), .busy(busyInt), .strb(strb)
  );

  ow_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdData(cmdData), .lineIn(lineIn),
    .txBit(txBit), .rspValid(rspValid), .rspData(rspData),
    .rspPresence(rspPresence)
  );

  assign busy     = busyInt;
  assign cmdReady = !busyInt;
  assign lineOe   = strb.lineLow;
endmodule

// File: rtl/ow_checker.sv
module ow_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [1:0]        cmdKind,
  input logic              busy,
  input logic              rspValid,
  input logic [DATA_W-1:0] rspData,
  input logic              rspPresence,
  input logic              lineOe
);
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && cmdKind != 2'b11) |=> busy);

  a_r11_reserved_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy && cmdKind == 2'b11) |=> !busy);

  a_r10_end_with_rsp: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || rspValid));

  a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  a_r10_rsp_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (!busy && $past(busy)));

  a_r6_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !lineOe);

  a_r10_hold_results: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> ($stable(rspData) && $stable(rspPresence)));
endmodule

bind onewire_master ow_checker #(.DATA_W(DATA_W)) u_owChk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .cmdKind(cmdKind), .busy(busy), .rspValid(rspValid), .rspData(rspData),
  .rspPresence(rspPresence), .lineOe(lineOe)
);

// File: tb/tb_onewire_master.sv
`timescale 1ns/1ps
module tb_onewire_master;
  localparam int MHZ = 1;
  localparam int DIV = MHZ * 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [1:0] cmdKind = 2'b00;
  logic [7:0] cmdData = 8'h00;
  logic       cmdReady, busy, rspValid, rspPresence, lineOe, lineIn;
  logic [7:0] rspData;
  logic       devPull = 1'b0;

  always #5 clk = ~clk;

  assign lineIn = ~(lineOe | devPull);

  onewire_master #(.CLK_MHZ(MHZ), .DATA_W(8)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdKind(cmdKind), .cmdData(cmdData), .busy(busy), .rspValid(rspValid),
    .rspData(rspData), .rspPresence(rspPresence), .lineIn(lineIn),
    .lineOe(lineOe)
  );

  int nCmp = 0;
  int nBad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int seqTicks(input int kind);
    if (kind == 0) return 170;
    if (kind == 1) return 12;
    return 96;
  endfunction

  function automatic bit expOe(input int kind, input int cnt, input logic [7:0] d);
    int tick, slot, p;
    bit b;
    tick = cnt / DIV;
    if (kind == 0) return (tick >= 10) && (tick < 90);
    slot = tick / 12;
    p    = tick % 12;
    b    = (kind == 2) ? d[slot] : d[0];
    return (p == 2) || ((p > 2) && !b);
  endfunction

  // reference model, compared on every clock
  bit         mBusy = 0, mRsp = 0;
  int         mCnt = 0, mKind = 0;
  logic [7:0] mData = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      mBusy = 0; mRsp = 0; mCnt = 0;
    end else begin
      chk(busy === mBusy, "R10 R3 busy", busy, mBusy);
      chk(cmdReady === !mBusy, "R2 cmdReady", cmdReady, !mBusy);
      chk(lineOe === (mBusy && expOe(mKind, mCnt, mData)), "R3 R4 R6 lineOe",
          lineOe, mBusy && expOe(mKind, mCnt, mData));
      chk(rspValid === mRsp, "R10 R11 rspValid", rspValid, mRsp);
      mRsp = 0;
      if (mBusy) begin
        if (mCnt == seqTicks(mKind) * DIV - 1) begin
          mBusy = 0; mRsp = 1;
        end else mCnt++;
      end else if (cmdValid && cmdKind != 2'b11) begin
        mBusy = 1; mCnt = 0; mKind = int'(cmdKind); mData = cmdData;
      end
    end
  end

  // behavioural device
  int         devMode = 0;       // 0 silent, 1 presence, 2 slot bits
  logic [7:0] devBits = 8'hFF;
  int         devIdx = 0;
  int         pDelay = 0, pWidth = 0;
  int         pullCnt = 0, presDelay = 0;
  bit         presArm = 0, prevOe = 0;

  always @(negedge clk) begin
    if (devMode == 2 && lineOe && !prevOe) begin
      if (!devBits[devIdx % 8]) pullCnt = 4 * DIV;
      devIdx++;
    end
    if (devMode == 1 && !lineOe && prevOe) begin
      presArm = 1; presDelay = pDelay;
    end
    if (presArm) begin
      if (presDelay > 0) presDelay--;
      else begin pullCnt = pWidth; presArm = 0; end
    end
    devPull = (pullCnt > 0);
    if (pullCnt > 0) pullCnt--;
    prevOe = lineOe;
  end

  task automatic issue(input logic [1:0] kind, input logic [7:0] data);
    @(posedge clk); #1;
    cmdValid = 1'b1; cmdKind = kind; cmdData = data;
    @(posedge clk); #1;
    cmdValid = 1'b0;
  endtask

  task automatic waitRsp(input string tag);
    bit got = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (rspValid) begin got = 1; break; end
    end
    if (!got) begin
      nCmp++; nBad++;
      $display("FAIL %s no response actual=0 expected=1", tag);
    end
  endtask

  task automatic runReset(input int dly, input int wid, input bit usePull,
                          input bit expPres, input logic [7:0] keepData, input string tag);
    devMode = usePull ? 1 : 0; pDelay = dly; pWidth = wid;
    issue(2'b00, 8'h00);
    waitRsp(tag);
    chk(rspPresence === expPres, tag, rspPresence, expPres);
    chk(rspData === keepData, "R10 reset keeps rspData", rspData, keepData);
    devMode = 0;
  endtask

  task automatic runBit(input bit tx, input bit dev, input bit keepPres, input string tag);
    logic [7:0] e;
    devMode = 2; devBits = {7'h7F, dev}; devIdx = 0;
    issue(2'b01, {7'h55, tx});
    waitRsp(tag);
    e = {7'b0, tx & dev};
    chk(rspData === e, tag, rspData, e);
    chk(rspPresence === keepPres, "R10 bit keeps rspPresence", rspPresence, keepPres);
    devMode = 0;
  endtask

  task automatic runByte(input logic [7:0] tx, input logic [7:0] dev, input string tag);
    logic [7:0] e;
    devMode = 2; devBits = dev; devIdx = 0;
    issue(2'b10, tx);
    waitRsp(tag);
    e = tx & dev;
    chk(rspData === e, tag, rspData, e);
    devMode = 0;
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nBad++;
      $display("FAIL watchdog actual=%0d expected<=150000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(cmdReady === 1'b1, "R1 cmdReady", cmdReady, 1);
    chk(lineOe === 1'b0, "R1 lineOe", lineOe, 0);
    chk(rspValid === 1'b0, "R1 rspValid", rspValid, 0);
    chk(rspData === 8'h00, "R1 rspData", rspData, 0);
    chk(rspPresence === 1'b0, "R1 rspPresence", rspPresence, 0);

    // R4 R5 presence cases
    runReset(0, 0, 0, 0, 8'h00, "R5 no device");
    runReset(15, 120, 1, 1, 8'h00, "R5 normal presence");

    // R7 R9 single slots
    runBit(1, 1, 1, "R7 R9 bit 1 line high");
    runBit(1, 0, 1, "R7 R9 bit 1 line pulled");
    runBit(0, 1, 1, "R7 R9 bit 0 records zero");

    // R8 bytes
    runByte(8'hFF, 8'hA5, "R8 read byte");
    runByte(8'h5A, 8'h0F, "R8 mixed byte");
    runByte(8'h3C, 8'hFF, "R8 write byte");

    // R2 command while busy is ignored
    devMode = 2; devBits = 8'hFF; devIdx = 0;
    issue(2'b10, 8'h81);
    repeat (20) @(posedge clk);
    #1 cmdValid = 1'b1; cmdKind = 2'b00; cmdData = 8'h00;
    repeat (5) @(posedge clk);
    #1 cmdValid = 1'b0;
    waitRsp("R2 busy ignore");
    chk(rspData === 8'h81, "R2 busy ignore data", rspData, 8'h81);
    devMode = 0;

    // R11 reserved code
    @(posedge clk); #1;
    cmdValid = 1'b1; cmdKind = 2'b11; cmdData = 8'hC3;
    repeat (4) @(posedge clk);
    #1 cmdValid = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy === 1'b0, "R11 reserved busy", busy, 0);
    chk(rspData === 8'h81, "R11 reserved rspData", rspData, 8'h81);

    // R5 boundary windows
    runReset(100, 14, 1, 1, 8'h81, "R5 short pulse between samples");
    runReset(410, 40, 1, 0, 8'h81, "R5 pulse after last sample");
    runReset(2, 15, 1, 0, 8'h81, "R5 pulse before first sample");

    repeat (10) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule